// File: doc/BRIEF.md
# Precise Exception Redirect Unit

This unit sits beside the control logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and makes synchronous exceptions precise. When the instruction in execute reports a fault, or decode reports an opcode it cannot recognise, the unit marks the faulting instruction and every younger instruction for removal. The pipeline turns each of them into a bubble, so none of them writes a register or memory. Older instructions in memory and writeback are left alone and retire.

In the same cycle the unit overrides the next fetch address with a fixed handler entry point. The fetch stage therefore reads the handler's first instruction on the following cycle. At that clock edge the unit also stores the faulting instruction's PC and a cause code in two registers.

The same kill-and-redirect path carries a taken branch resolved in decode. A branch removes only the instruction that was fetched behind it and steers fetch to the branch target. An exception in the same cycle takes precedence over the branch.

Top module: `exc_redirect`

## Requirements
- R1: While reset is held, and after it is released, the saved PC and the saved cause both read zero. With no request present, no flush bit is set and no redirect is requested.
- R2: An exception is accepted from execute when the execute slot is valid and the execute fault input is high. In that cycle the redirect is asserted and the next-PC override equals the handler address 0x1C090000.
- R3: The flush vector uses bit 0 for fetch, bit 1 for decode, bit 2 for execute, bit 3 for memory and bit 4 for writeback. An accepted execute exception sets bits 0, 1 and 2 and clears bits 3 and 4, so the faulting instruction itself never writes back.
- R4: On the clock edge that ends the cycle of an accepted execute exception, the saved PC takes the execute-stage PC and the saved cause takes the cause input unchanged. Callers use 8 for an environment call and 24 for an arithmetic fault.
- R5: An undefined opcode flagged in a valid decode slot, with no execute exception, is accepted with cause 2. The saved PC is the decode PC, only flush bits 0 and 1 are set, and fetch is redirected to the handler.
- R6: When execute and decode both raise exceptions in the same cycle, the execute (older) one is reported. Its PC and cause are saved and its flush pattern is used.
- R7: In a cycle with no accepted exception, the saved PC and cause keep their values. A fault or undefined-opcode flag whose stage is not valid is ignored.
- R8: A taken branch in a valid decode slot, with no accepted exception, sets only flush bit 0 and redirects fetch to the branch target. It leaves the saved PC and cause unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_vld_i | input | NSTAGE | Per-stage valid bits, index 0 = fetch |
| stage_pc_i | input | NSTAGE x XLEN | Per-stage instruction PCs, packed, index 0 = fetch |
| ex_exc_i | input | 1 | Execute-stage instruction raised a fault |
| ex_cause_i | input | CAUSE_W | Cause code for the execute-stage fault |
| id_undef_i | input | 1 | Decode found an undefined opcode |
| id_br_taken_i | input | 1 | Decode resolved a taken branch |
| id_br_target_i | input | XLEN | Target of the taken branch |
| flush_o | output | NSTAGE | Kill bits, one per stage, set bit turns the slot into a bubble |
| redir_vld_o | output | 1 | Override the next fetch PC |
| redir_pc_o | output | XLEN | Next fetch PC when overriding |
| epc_o | output | XLEN | Saved PC of the last accepted exception |
| cause_o | output | CAUSE_W | Saved cause of the last accepted exception |

## Verification
The checker assumes the stage valid bits describe the pipeline as the surrounding control sees it. It also assumes the caller gives a cause code only together with the execute fault flag, and that the branch target only matters while the branch flag is high. The stimulus sweeps every combination of decode and execute validity, fault, undefined opcode and branch flags, under two cause codes. Every input is held steady for a full cycle. PCs step by instruction size between stages, so a wrong stage selection shows up as a different saved PC.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W        = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_UNDEF_OP = CAUSE_W'(2);
  localparam logic [CAUSE_W-1:0] CAUSE_ECALL    = CAUSE_W'(8);
  localparam logic [CAUSE_W-1:0] CAUSE_ARITH    = CAUSE_W'(24);
endpackage

// File: rtl/exc_prio.sv
// Collects exception requests per stage and picks the oldest one.
module exc_prio
  import exc_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NSTAGE = 5,
  parameter int ID_STG = 1,
  parameter int EX_STG = 2,
  localparam int SW    = $clog2(NSTAGE)
) (
  input  logic [NSTAGE-1:0]           stage_vld_i,
  input  logic [NSTAGE-1:0][XLEN-1:0] stage_pc_i,
  input  logic                        ex_exc_i,
  input  logic [CAUSE_W-1:0]          ex_cause_i,
  input  logic                        id_undef_i,
  output logic                        take_o,
  output logic [SW-1:0]               sel_stage_o,
  output logic [XLEN-1:0]             sel_pc_o,
  output logic [CAUSE_W-1:0]          sel_cause_o
);
  logic [NSTAGE-1:0]  req;
  logic [CAUSE_W-1:0] src_cause [NSTAGE];

  for (genvar s = 0; s < NSTAGE; s++) begin : g_src
    if (s == EX_STG) begin : g_ex
      assign req[s]       = stage_vld_i[s] & ex_exc_i;
      assign src_cause[s] = ex_cause_i;
    end else if (s == ID_STG) begin : g_id
      assign req[s]       = stage_vld_i[s] & id_undef_i;
      assign src_cause[s] = CAUSE_UNDEF_OP;
    end else begin : g_none
      assign req[s]       = 1'b0;
      assign src_cause[s] = '0;
    end
  end

  // Higher index is further down the pipe, hence older: last match wins.
  always_comb begin
    take_o      = 1'b0;
    sel_stage_o = '0;
    sel_pc_o    = '0;
    sel_cause_o = '0;
    for (int s = 0; s < NSTAGE; s++) begin
      if (req[s]) begin
        take_o      = 1'b1;
        sel_stage_o = SW'(s);
        sel_pc_o    = stage_pc_i[s];
        sel_cause_o = src_cause[s];
      end
    end
  end
endmodule

// File: rtl/exc_flush.sv
// Builds kill bits and the fetch override from the selected event.
module exc_flush #(
  parameter int XLEN               = 64,
  parameter int NSTAGE             = 5,
  parameter logic [XLEN-1:0] HANDLER_PC = XLEN'(64'h1C09_0000),
  localparam int SW                = $clog2(NSTAGE)
) (
  input  logic              take_i,
  input  logic [SW-1:0]     sel_stage_i,
  input  logic              br_take_i,
  input  logic [XLEN-1:0]   br_target_i,
  output logic [NSTAGE-1:0] flush_o,
  output logic              redir_vld_o,
  output logic [XLEN-1:0]   redir_pc_o
);
  for (genvar s = 0; s < NSTAGE; s++) begin : g_kill
    if (s == 0) begin : g_fetch
      assign flush_o[s] = take_i | br_take_i;
    end else begin : g_rest
      assign flush_o[s] = take_i & (SW'(s) <= sel_stage_i);
    end
  end

  assign redir_vld_o = take_i | br_take_i;
  assign redir_pc_o  = take_i ? HANDLER_PC : (br_take_i ? br_target_i : '0);
endmodule

// File: rtl/exc_csr.sv
// Saved PC and cause; written only on an accepted exception.
module exc_csr
  import exc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      epc_o   <= '0;
      cause_o <= '0;
    end else if (take_i) begin
      epc_o   <= pc_i;
      cause_o <= cause_i;
    end
  end
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_pkg::*;
#(
  parameter int XLEN               = 64,
  parameter int NSTAGE             = 5,
  parameter int ID_STG             = 1,
  parameter int EX_STG             = 2,
  parameter logic [XLEN-1:0] HANDLER_PC = XLEN'(64'h1C09_0000)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NSTAGE-1:0]           stage_vld_i,
  input  logic [NSTAGE-1:0][XLEN-1:0] stage_pc_i,
  input  logic                        ex_exc_i,
  input  logic [CAUSE_W-1:0]          ex_cause_i,
  input  logic                        id_undef_i,
  input  logic                        id_br_taken_i,
  input  logic [XLEN-1:0]             id_br_target_i,
  output logic [NSTAGE-1:0]           flush_o,
  output logic                        redir_vld_o,
  output logic [XLEN-1:0]             redir_pc_o,
  output logic [XLEN-1:0]             epc_o,
  output logic [CAUSE_W-1:0]          cause_o
);
  localparam int SW = $clog2(NSTAGE);

  logic               take;
  logic [SW-1:0]      sel_stage;
  logic [XLEN-1:0]    sel_pc;
  logic [CAUSE_W-1:0] sel_cause;
  logic               br_take;

  assign br_take = stage_vld_i[ID_STG] & id_br_taken_i & ~take;

  exc_prio #(
    .XLEN(XLEN), .NSTAGE(NSTAGE), .ID_STG(ID_STG), .EX_STG(EX_STG)
  ) u_prio (
    .stage_vld_i (stage_vld_i),
    .stage_pc_i  (stage_pc_i),
    .ex_exc_i    (ex_exc_i),
    .ex_cause_i  (ex_cause_i),
    .id_undef_i  (id_undef_i),
    .take_o      (take),
    .sel_stage_o (sel_stage),
    .sel_pc_o    (sel_pc),
    .sel_cause_o (sel_cause)
  );

  exc_flush #(
    .XLEN(XLEN), .NSTAGE(NSTAGE), .HANDLER_PC(HANDLER_PC)
  ) u_flush (
    .take_i      (take),
    .sel_stage_i (sel_stage),
    .br_take_i   (br_take),
    .br_target_i (id_br_target_i),
    .flush_o     (flush_o),
    .redir_vld_o (redir_vld_o),
    .redir_pc_o  (redir_pc_o)
  );

  exc_csr #(
    .XLEN(XLEN)
  ) u_csr (
    .clk     (clk),
    .rst     (rst),
    .take_i  (take),
    .pc_i    (sel_pc),
    .cause_i (sel_cause),
    .epc_o   (epc_o),
    .cause_o (cause_o)
  );
endmodule

// File: rtl/exc_redirect_chk.sv
module exc_redirect_chk
  import exc_pkg::*;
#(
  parameter int XLEN               = 64,
  parameter int NSTAGE             = 5,
  parameter int ID_STG             = 1,
  parameter int EX_STG             = 2,
  parameter logic [XLEN-1:0] HANDLER_PC = XLEN'(64'h1C09_0000)
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NSTAGE-1:0]           stage_vld_i,
  input logic [NSTAGE-1:0][XLEN-1:0] stage_pc_i,
  input logic                        ex_exc_i,
  input logic [CAUSE_W-1:0]          ex_cause_i,
  input logic                        id_undef_i,
  input logic                        id_br_taken_i,
  input logic [XLEN-1:0]             id_br_target_i,
  input logic [NSTAGE-1:0]           flush_o,
  input logic                        redir_vld_o,
  input logic [XLEN-1:0]             redir_pc_o,
  input logic [XLEN-1:0]             epc_o,
  input logic [CAUSE_W-1:0]          cause_o
);
  logic ex_req, id_req, br_req;
  assign ex_req = stage_vld_i[EX_STG] & ex_exc_i;
  assign id_req = stage_vld_i[ID_STG] & id_undef_i;
  assign br_req = stage_vld_i[ID_STG] & id_br_taken_i;

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !(ex_req || id_req || br_req) |-> (flush_o == '0) && !redir_vld_o);

  p_handler_r2: assert property (@(posedge clk) disable iff (rst)
    ex_req |-> redir_vld_o && (redir_pc_o == HANDLER_PC));

  p_flush_ex_r3: assert property (@(posedge clk) disable iff (rst)
    ex_req |-> flush_o[EX_STG] && flush_o[0] && !flush_o[EX_STG+1]);

  p_flush_shape_r3: assert property (@(posedge clk) disable iff (rst)
    (flush_o & (flush_o + 1'b1)) == '0);

  p_save_r4: assert property (@(posedge clk) disable iff (rst)
    ex_req |=> (epc_o == $past(stage_pc_i[EX_STG])) && (cause_o == $past(ex_cause_i)));

  p_undef_r5: assert property (@(posedge clk) disable iff (rst)
    (id_req && !ex_req) |=> (cause_o == CAUSE_UNDEF_OP) && (epc_o == $past(stage_pc_i[ID_STG])));

  p_oldest_r6: assert property (@(posedge clk) disable iff (rst)
    (ex_req && id_req) |-> flush_o[EX_STG]);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(ex_req || id_req) |=> $stable(epc_o) && $stable(cause_o));

  p_branch_r8: assert property (@(posedge clk) disable iff (rst)
    (br_req && !ex_req && !id_req) |-> (flush_o == NSTAGE'(1)) && (redir_pc_o == id_br_target_i));
endmodule

bind exc_redirect exc_redirect_chk #(
  .XLEN(XLEN), .NSTAGE(NSTAGE), .ID_STG(ID_STG), .EX_STG(EX_STG), .HANDLER_PC(HANDLER_PC)
) u_chk (
  .clk(clk), .rst(rst), .stage_vld_i(stage_vld_i), .stage_pc_i(stage_pc_i),
  .ex_exc_i(ex_exc_i), .ex_cause_i(ex_cause_i), .id_undef_i(id_undef_i),
  .id_br_taken_i(id_br_taken_i), .id_br_target_i(id_br_target_i),
  .flush_o(flush_o), .redir_vld_o(redir_vld_o), .redir_pc_o(redir_pc_o),
  .epc_o(epc_o), .cause_o(cause_o)
);

// File: tb/exc_redirect_bench.sv
`timescale 1ns/1ps
module exc_redirect_bench;
  localparam int XLEN   = 64;
  localparam int NSTAGE = 5;
  localparam int CW     = exc_pkg::CAUSE_W;
  localparam logic [XLEN-1:0] HANDLER = 64'h1C09_0000;

  logic                        clk = 1'b0;
  logic                        rst = 1'b1;
  logic [NSTAGE-1:0]           stage_vld_i = '0;
  logic [NSTAGE-1:0][XLEN-1:0] stage_pc_i = '0;
  logic                        ex_exc_i = 1'b0;
  logic [CW-1:0]               ex_cause_i = '0;
  logic                        id_undef_i = 1'b0;
  logic                        id_br_taken_i = 1'b0;
  logic [XLEN-1:0]             id_br_target_i = '0;
  logic [NSTAGE-1:0]           flush_o;
  logic                        redir_vld_o;
  logic [XLEN-1:0]             redir_pc_o;
  logic [XLEN-1:0]             epc_o;
  logic [CW-1:0]               cause_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [XLEN-1:0] exp_epc   = '0;
  logic [CW-1:0]   exp_cause = '0;

  always #2 clk = ~clk;

  exc_redirect u_exc_redirect (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input bit vid, input bit vex, input bit exx, input bit und,
                          input bit br, input logic [CW-1:0] cz, input int idx);
    logic [XLEN-1:0] base;
    logic [NSTAGE-1:0] e_flush;
    bit ex_t, id_t, br_t, e_rv;
    logic [XLEN-1:0] e_rpc;
    string tag_f, tag_r, tag_s;
    base = 64'h4C + XLEN'(idx) * 64'h100;
    @(negedge clk);
    stage_vld_i    = {1'b1, 1'b1, vex, vid, 1'b1};
    for (int s = 0; s < NSTAGE; s++) stage_pc_i[s] = base + 64'h8 - XLEN'(4 * s);
    ex_exc_i       = exx;
    ex_cause_i     = cz;
    id_undef_i     = und;
    id_br_taken_i  = br;
    id_br_target_i = base + 64'h2000;
    ex_t = vex & exx;
    id_t = vid & und;
    br_t = vid & br;
    e_flush = ex_t ? 5'b00111 : id_t ? 5'b00011 : br_t ? 5'b00001 : 5'b00000;
    e_rv    = ex_t | id_t | br_t;
    e_rpc   = (ex_t | id_t) ? HANDLER : br_t ? base + 64'h2000 : '0;
    tag_f = (ex_t && id_t) ? "R6" : ex_t ? "R3" : id_t ? "R5" : br_t ? "R8" : "R1";
    tag_r = (ex_t && id_t) ? "R6" : ex_t ? "R2" : id_t ? "R5" : br_t ? "R8" : "R1";
    tag_s = (ex_t && id_t) ? "R6" : ex_t ? "R4" : id_t ? "R5" : "R7";
    #1;
    check(flush_o == e_flush, tag_f, "flush", XLEN'(flush_o), XLEN'(e_flush));
    check(redir_vld_o == e_rv, tag_r, "redirect valid", XLEN'(redir_vld_o), XLEN'(e_rv));
    if (e_rv) check(redir_pc_o == e_rpc, tag_r, "redirect pc", redir_pc_o, e_rpc);
    if (ex_t) begin
      exp_epc = base; exp_cause = cz;
    end else if (id_t) begin
      exp_epc = base + 64'h4; exp_cause = CW'(2);
    end
    @(posedge clk); #1;
    check(epc_o == exp_epc, tag_s, "saved pc", epc_o, exp_epc);
    check(cause_o == exp_cause, tag_s, "saved cause", XLEN'(cause_o), XLEN'(exp_cause));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check(epc_o == '0, "R1", "saved pc in reset", epc_o, '0);
    check(cause_o == '0, "R1", "saved cause in reset", XLEN'(cause_o), '0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check(flush_o == '0, "R1", "flush idle", XLEN'(flush_o), '0);
    check(redir_vld_o == 1'b0, "R1", "redirect idle", XLEN'(redir_vld_o), '0);
    check(epc_o == '0, "R1", "saved pc after reset", epc_o, '0);
    // Exhaustive sweep of flags under two cause codes (8 ecall, 24 arithmetic)
    for (int c = 0; c < 2; c++) begin
      for (int m = 0; m < 32; m++) begin
        run_case(m[0], m[1], m[2], m[3], m[4], (c == 0) ? CW'(8) : CW'(24), c * 32 + m);
      end
    end
    finish_run();
  end
endmodule